// File: doc/BRIEF.md
# Alert Response Responder

This block lets a device that has raised an active-low alert answer the host's alert query on a two-wire serial bus. It does not decode bus conditions itself. An upstream decoder hands it single-cycle event strobes: start, stop, a completed address byte, and the rising and falling edges of the serial clock. It also receives the sampled data line. The block holds the alert-pending flag. A one-cycle request sets the flag, and while the flag is set the alert output stays low.

When an address byte arrives that carries the fixed query address (7-bit 0x0C) with the read bit set, and an alert is pending, the block acknowledges on the ninth clock. It then shifts out a data byte through an open-drain pull-down. Its own 7-bit address sits in bits 7:1 and a released 1 sits in bit 0. On every data bit it compares what it released with what the line shows. Other alerting devices may be driving the line at the same time. The lowest address therefore wins by wired-AND arbitration. Only a win clears the pending alert. A loss leaves the alert asserted so that the device can answer a later query.

Top module: `alert_resp_responder`

## Requirements
- R1: After reset the alert output is high, the data pull-down is off, and neither the won nor the lost strobe is active.
- R2: A one-cycle `alert_req` sets the pending flag, which drives `alert_n` low until a won arbitration clears it. When a request and a win fall in the same cycle, the request wins.
- R3: Only an address byte equal to {ARA_ADDR, 1'b1} (0x19 with defaults) starts a response. Any other byte, including the write form 0x18, causes no pull-down at any point.
- R4: A matching query that arrives while no alert is pending is ignored: there is no acknowledge, no data is driven and the alert state does not change.
- R5: On a response, `sda_pull` is high from the first SCL fall after the address byte to the second one (the ninth-clock acknowledge).
- R6: The data byte is sent MSB first as {DEV_ADDR, 1'b1}. Each bit is set up on an SCL fall, and a 0 bit is sent by pulling SDA low.
- R7: If the device releases SDA for a 1 and samples 0 at an SCL rise, `arb_lost` pulses for one cycle, SDA stays released for the rest of the byte, and `alert_n` stays low.
- R8: If all eight data bits complete without a loss, `arb_won` pulses at the eighth rise, the pending flag clears and `alert_n` returns high.
- R9: After the data byte, the master's acknowledge clock draws no drive. A start or stop at any time returns the block to idle with SDA released, and the pending flag is unaffected by the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alert_req | input | 1 | One-cycle request to raise the alert |
| bus_start | input | 1 | Start (or repeated start) seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| addr_valid | input | 1 | Address byte received, valid for one cycle |
| addr_byte | input | 8 | Received address byte, address in 7:1, read/write in 0 |
| scl_rise | input | 1 | SCL rising edge strobe |
| scl_fall | input | 1 | SCL falling edge strobe |
| sda_in | input | 1 | Sampled SDA line level |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| alert_n | output | 1 | Active-low alert line |
| arb_won | output | 1 | One-cycle strobe: response sent, alert cleared |
| arb_lost | output | 1 | One-cycle strobe: arbitration lost |

## Verification
The bench models the wired-AND line with a second alerting device. It picks an opponent address that makes this device lose at bit 5 and then outbid it with 1s at lower bits. A design that kept driving after a loss would pull those bits to 0 and corrupt the received byte. A higher opponent checks that a win clears the alert, while a design that cleared on loss would raise `alert_n` too early. The bench also sends the write form of the query address and a valid query with no alert pending; a loose address compare or a missing pending gate would show up as a spurious acknowledge. A start in the middle of the data byte must release the line and keep the alert pending, and the next query must then win.

// File: rtl/arr_pkg.sv
package arr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } arr_state_e;
endpackage

// File: rtl/arr_pending.sv
module arr_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic pend
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (clr_req) pend_d = 1'b0;
    if (set_req) pend_d = 1'b1;   // a new request outranks a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  a_r2_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> pend);
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !pend);
endmodule

// File: rtl/arr_arbiter.sv
module arr_arbiter #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h39
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift_en,
  input  logic sample,
  input  logic sda_in,
  output logic drive_low,
  output logic lost_now,
  output logic win_now,
  output logic last_bit
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              lost_q, lost_d;

  assign drive_low = !lost_q && !shift_q[BYTE_W-1];
  assign lost_now  = sample && !lost_q && shift_q[BYTE_W-1] && !sda_in;
  assign last_bit  = (cnt_q == LAST_CNT);
  assign win_now   = sample && last_bit && !lost_q && !lost_now;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    lost_d  = lost_q;
    if (load) begin
      shift_d = {DEV_ADDR, 1'b1};
      cnt_d   = '0;
      lost_d  = 1'b0;
    end else begin
      if (shift_en) shift_d = {shift_q[BYTE_W-2:0], 1'b1};
      if (sample) begin
        if (!last_bit) cnt_d = cnt_q + 1'b1;
        if (lost_now)  lost_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      cnt_q   <= '0;
      lost_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      lost_q  <= lost_d;
    end
  end

  a_r7_no_drive_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_now && !load) |=> !drive_low);
  a_r7_win_lost_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_now && lost_now));
endmodule

// File: rtl/alert_resp_responder.sv
module alert_resp_responder #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h39,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alert_req,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_valid,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic              alert_n,
  output logic              arb_won,
  output logic              arb_lost
);
  import arr_pkg::*;

  localparam logic [ADDR_W:0] QUERY_RD = {ARA_ADDR, 1'b1};

  arr_state_e state_q, state_d;
  logic ack_on_q, ack_on_d;
  logic abort, pend, load, shift_en, sample;
  logic drive_low, lost_now, win_now, last_bit;

  assign abort    = bus_start || bus_stop;
  assign load     = !abort && (state_q == ST_ACK) && scl_fall && ack_on_q;
  assign shift_en = !abort && (state_q == ST_DATA) && scl_fall;
  assign sample   = !abort && (state_q == ST_DATA) && scl_rise;

  always_comb begin
    state_d  = state_q;
    ack_on_d = ack_on_q;
    if (abort) begin
      state_d  = ST_IDLE;
      ack_on_d = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (addr_valid && addr_byte == QUERY_RD && pend) begin
          state_d  = ST_ACK;
          ack_on_d = 1'b0;
        end
        ST_ACK: if (scl_fall) begin
          if (!ack_on_q) ack_on_d = 1'b1;
          else begin
            ack_on_d = 1'b0;
            state_d  = ST_DATA;
          end
        end
        ST_DATA: if (sample && last_bit) state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ack_on_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      ack_on_q <= ack_on_d;
    end
  end

  arr_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (alert_req),
    .clr_req (win_now),
    .pend    (pend)
  );

  arr_arbiter #(
    .ADDR_W   (ADDR_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .shift_en  (shift_en),
    .sample    (sample),
    .sda_in    (sda_in),
    .drive_low (drive_low),
    .lost_now  (lost_now),
    .win_now   (win_now),
    .last_bit  (last_bit)
  );

  assign sda_pull = ((state_q == ST_ACK) && ack_on_q) ||
                    ((state_q == ST_DATA) && drive_low);
  assign alert_n  = !pend;
  assign arb_won  = win_now;
  assign arb_lost = lost_now;

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_DONE) |-> !sda_pull);
  a_r9_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !sda_pull);
  a_r8_win_raises_alert: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_won && !alert_req) |=> alert_n);
  a_r7_loss_keeps_alert: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !alert_n);
  a_r4_ack_needs_alert: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_on_q) && state_q == ST_ACK) |-> !alert_n);
endmodule

// File: tb/alert_resp_responder_tb.sv
`timescale 1ns/1ps
module alert_resp_responder_tb;
  logic clk, rst_n, alert_req, bus_start, bus_stop, addr_valid;
  logic [7:0] addr_byte;
  logic scl_rise, scl_fall, sda_in;
  logic sda_pull, alert_n, arb_won, arb_lost;

  int n_tests, n_fail, won_cnt, lost_cnt;
  bit done;

  alert_resp_responder u_dut (
    .clk(clk), .rst_n(rst_n), .alert_req(alert_req), .bus_start(bus_start),
    .bus_stop(bus_stop), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .sda_pull(sda_pull), .alert_n(alert_n), .arb_won(arb_won), .arb_lost(arb_lost)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (arb_won)  won_cnt  <= won_cnt + 1;
    if (arb_lost) lost_cnt <= lost_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask
  task automatic pulse_stop();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask
  task automatic pulse_alert();
    alert_req = 1'b1; @(negedge clk); alert_req = 1'b0;
  endtask
  task automatic send_addr(input logic [7:0] b);
    addr_byte = b; addr_valid = 1'b1; @(negedge clk); addr_valid = 1'b0;
  endtask

  // one SCL period: fall, observe our pull, resolve wired-AND, rise
  task automatic bit_clock(input bit other, output bit pulled, output bit line);
    scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
    pulled = sda_pull;
    line = other & !pulled;
    sda_in = line;
    scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0;
    @(negedge clk);
    sda_in = 1'b1;
  endtask

  // full query: address byte, ack clock, data byte, master ack clock
  task automatic query(input logic [7:0] abyte, input logic [7:0] other,
                       output bit ack, output logic [7:0] rx, output int drv_bits,
                       output bit tail_pull);
    bit p, l;
    pulse_start();
    send_addr(abyte);
    bit_clock(1'b1, ack, l);
    drv_bits = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_clock(other[i], p, l);
      rx[i] = l;
      if (p) drv_bits++;
    end
    bit_clock(1'b0, tail_pull, l);
    pulse_stop();
  endtask

  task automatic t_reset();
    chk(alert_n === 1'b1, "R1 alert_n after reset", alert_n, 1);
    chk(sda_pull === 1'b0, "R1 sda_pull after reset", sda_pull, 0);
    chk(won_cnt == 0 && lost_cnt == 0, "R1 no strobes", won_cnt + lost_cnt, 0);
  endtask

  task automatic t_wrong_addr();
    bit ack, tp; logic [7:0] rx; int d;
    pulse_alert();
    chk(alert_n === 1'b0, "R2 alert asserted", alert_n, 0);
    query(8'h18, 8'hFF, ack, rx, d, tp);
    chk(!ack && d == 0, "R3 write form ignored", d, 0);
    query(8'h1B, 8'hFF, ack, rx, d, tp);
    chk(!ack && rx == 8'hFF, "R3 other address ignored", rx, 8'hFF);
    chk(alert_n === 1'b0, "R3 alert untouched", alert_n, 0);
  endtask

  task automatic t_win_alone();
    bit ack, tp; logic [7:0] rx; int d; int w0;
    w0 = won_cnt;
    query(8'h19, 8'hFF, ack, rx, d, tp);
    chk(ack, "R5 ack on ninth clock", ack, 1);
    chk(rx == 8'h73, "R6 returned byte", rx, 8'h73);
    chk(!tp, "R9 master ack clock undriven", tp, 0);
    chk(won_cnt == w0 + 1, "R8 won strobe", won_cnt - w0, 1);
    chk(alert_n === 1'b1, "R8 alert released", alert_n, 1);
  endtask

  task automatic t_no_pending();
    bit ack, tp; logic [7:0] rx; int d; int w0;
    w0 = won_cnt;
    query(8'h19, 8'hFF, ack, rx, d, tp);
    chk(!ack && d == 0, "R4 no response without alert", d, 0);
    chk(won_cnt == w0 && alert_n === 1'b1, "R4 state unchanged", won_cnt - w0, 0);
  endtask

  task automatic t_lose();
    bit ack, tp; logic [7:0] rx; int d; int l0, w0;
    pulse_alert();
    l0 = lost_cnt; w0 = won_cnt;
    query(8'h19, 8'h5F, ack, rx, d, tp);   // opponent 0x2F outbids at bit 5
    chk(rx == 8'h5F, "R7 released after loss", rx, 8'h5F);
    chk(lost_cnt == l0 + 1 && won_cnt == w0, "R7 lost strobe", lost_cnt - l0, 1);
    chk(alert_n === 1'b0, "R7 alert kept", alert_n, 0);
  endtask

  task automatic t_win_contest();
    bit ack, tp; logic [7:0] rx; int d; int w0;
    w0 = won_cnt;
    query(8'h19, 8'h77, ack, rx, d, tp);   // opponent 0x3B is higher
    chk(rx == 8'h73, "R6 wired-AND result", rx, 8'h73);
    chk(won_cnt == w0 + 1 && alert_n === 1'b1, "R8 win over higher", won_cnt - w0, 1);
  endtask

  task automatic t_abort();
    bit p, l, ack, tp; logic [7:0] rx; int d; int w0;
    pulse_alert();
    w0 = won_cnt;
    pulse_start();
    send_addr(8'h19);
    bit_clock(1'b1, p, l);
    bit_clock(1'b1, p, l);
    bit_clock(1'b1, p, l);
    pulse_start();
    chk(sda_pull === 1'b0, "R9 start releases", sda_pull, 0);
    bit_clock(1'b1, p, l);
    chk(!p && alert_n === 1'b0 && won_cnt == w0, "R9 alert kept on abort", p, 0);
    pulse_stop();
    query(8'h19, 8'hFF, ack, rx, d, tp);
    chk(rx == 8'h73 && alert_n === 1'b1, "R9 next query wins", rx, 8'h73);
  endtask

  task automatic t_set_vs_clear();
    bit p, l;
    pulse_alert();
    pulse_start();
    send_addr(8'h19);
    bit_clock(1'b1, p, l);
    for (int i = 0; i < 7; i++) bit_clock(1'b1, p, l);
    scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
    sda_in = 1'b1; scl_rise = 1'b1; alert_req = 1'b1;
    @(negedge clk);
    scl_rise = 1'b0; alert_req = 1'b0;
    chk(alert_n === 1'b0, "R2 request beats clear", alert_n, 0);
    pulse_stop();
  endtask

  initial begin
    n_tests = 0; n_fail = 0; won_cnt = 0; lost_cnt = 0; done = 0;
    rst_n = 1'b0; alert_req = 0; bus_start = 0; bus_stop = 0; addr_valid = 0;
    addr_byte = 8'h00; scl_rise = 0; scl_fall = 0; sda_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrong_addr();
    t_win_alone();
    t_no_pending();
    t_lose();
    t_win_contest();
    t_abort();
    t_set_vs_clear();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule